// File: doc/BRIEF.md
# NAND ECC Engine Control Front-End

This block is the register-side controller for a hardware BCH error-correction engine that sits between a NAND flash and system memory. Software programs a mode word and two memory base addresses over a 32-bit register bus. One address points at a 512-byte data chunk. The other points at a single region that holds the spare (user) bytes followed by the parity bytes. A write to the launch register then starts an encode or a decode.

The front-end checks that both base addresses are word aligned. It snapshots the request and presents it for one cycle on a request interface. That interface goes to the DMA and codec, which in this project is a bench stub that answers after a fixed delay. While the operation runs, a busy flag is set. When the response arrives, the front-end latches three values into the status word: the failure flag, the erased-page flag and the corrected-bit count. It also pulses a completion output that can serve as an interrupt.

The spare region is 6 spare bytes plus 10 parity bytes (16 bytes) in the narrow mode. In the wide mode it is 6 spare bytes plus 20 parity bytes, rounded up to 28 bytes so that the transfer length stays a multiple of 4.

Top module: `nand_ecc_front`

## Requirements
- R1: After reset every register reads zero. busy_o, req_valid_o and done_pulse_o are low.
- R2: The mode register at offset 0x00 keeps only three fields. Bit 28 selects the wide mode (1 = 20 parity bytes, 0 = 10). Bit 12 is the exact-length transfer enable. Bits 1:0 are the burst code, where 2'b11 means 128-byte bursts. Every other bit reads 0. The data base at 0x0C and the spare base at 0x10 read back all 32 bits.
- R3: Consider a write to offset 0x08 while idle with both bases aligned. In the next cycle busy_o is set and req_valid_o is high for exactly one cycle. req_encode_o equals write bit 0 (1 = encode, 0 = decode). The request addresses equal the programmed bases.
- R4: req_data_len_o is 512. req_side_len_o is 16 in the narrow mode and 28 in the wide mode.
- R5: A launch write is ignored when either base has bits 1:0 nonzero. No request is issued, busy_o stays low and the status word is unchanged.
- R6: A launch write while busy is ignored. No second request is issued and busy_o stays set.
- R7: A response while busy has three effects at the same edge. busy_o clears. The status word at 0x14 shows the failure flag in bit 8, the erased flag in bit 4 and the count in bits 19:12. done_pulse_o is high for exactly the cycle that follows. Status bit 0 mirrors busy_o.
- R8: A response while idle is ignored. The status word is unchanged and no completion pulse occurs.
- R9: The result fields hold their values until the next accepted launch, which clears them to zero.
- R10: Reads of 0x04, 0x08 and unmapped offsets return zero. Writes to the status offset have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| req_valid_o | output | 1 | One-cycle operation request |
| req_encode_o | output | 1 | 1 = encode, 0 = decode |
| req_wide_o | output | 1 | Wide parity mode |
| req_exact_o | output | 1 | Exact-length transfer enable |
| req_burst_o | output | 2 | Burst size code |
| req_data_addr_o | output | 32 | Data chunk base address |
| req_side_addr_o | output | 32 | Spare/parity region base address |
| req_data_len_o | output | DLEN_W | Data chunk length in bytes |
| req_side_len_o | output | SLEN_W | Spare/parity region length in bytes |
| rsp_valid_i | input | 1 | Operation finished |
| rsp_fail_i | input | 1 | Uncorrectable decode |
| rsp_erased_i | input | 1 | Chunk read back as all ones |
| rsp_count_i | input | 8 | Number of corrected bits |
| busy_o | output | 1 | Operation in progress |
| done_pulse_o | output | 1 | One-cycle completion pulse |

## Verification
The bench drives an encode in the narrow mode and a decode in the wide mode. Comparing these two shows that the launch bit and the mode bit reach the request separately, and that the spare length switches between 16 and 28.

Responses are given with the failure flag alone, with the erased flag alone, and with all flags clear. Each time a different count is used, so a field landing at the wrong bit position or a stale value shows up.

Launches are also tried while busy and with each base misaligned in turn. These cases separate a correct rejection from an accidental start. A response is given while idle, and a stable status is read back, to show which events are allowed to change the status word and which are not.

// File: rtl/nand_ecc_front_pkg.sv
package nand_ecc_front_pkg;

  localparam int REG_W = 32;

  // register byte offsets (software-visible map)
  localparam int OFS_MODE   = 'h00;
  localparam int OFS_LAUNCH = 'h08;
  localparam int OFS_DBASE  = 'h0C;
  localparam int OFS_SBASE  = 'h10;
  localparam int OFS_STAT   = 'h14;

  // mode word fields
  localparam int MODE_WIDE_BIT  = 28;
  localparam int MODE_EXACT_BIT = 12;
  localparam int MODE_BURST_LO  = 0;

  // status word fields
  localparam int ST_BUSY_BIT   = 0;
  localparam int ST_ERASED_BIT = 4;
  localparam int ST_FAIL_BIT   = 8;
  localparam int ST_CNT_LO     = 12;
  localparam int ST_CNT_HI     = 19;
  localparam int CNT_W         = ST_CNT_HI - ST_CNT_LO + 1;

  typedef struct packed {
    logic       wide;
    logic       exact;
    logic [1:0] burst;
  } mode_t;

  function automatic int round_up4(input int n);
    return ((n + 3) / 4) * 4;
  endfunction

  function automatic logic word_aligned(input logic [REG_W-1:0] a);
    return (a[1:0] == 2'b00);
  endfunction

  function automatic logic [REG_W-1:0] mode_word(input mode_t m);
    logic [REG_W-1:0] w;
    w = '0;
    w[MODE_WIDE_BIT]               = m.wide;
    w[MODE_EXACT_BIT]              = m.exact;
    w[MODE_BURST_LO +: 2]          = m.burst;
    return w;
  endfunction

  function automatic logic [REG_W-1:0] status_word(input logic busy,
                                                   input logic erased,
                                                   input logic fail,
                                                   input logic [CNT_W-1:0] cnt);
    logic [REG_W-1:0] w;
    w = '0;
    w[ST_BUSY_BIT]         = busy;
    w[ST_ERASED_BIT]       = erased;
    w[ST_FAIL_BIT]         = fail;
    w[ST_CNT_LO +: CNT_W]  = cnt;
    return w;
  endfunction

endpackage

// File: rtl/nand_ecc_front_regs.sv
module nand_ecc_front_regs
  import nand_ecc_front_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [REG_W-1:0]    bus_wdata,
  output logic [REG_W-1:0]    bus_rdata,
  input  logic [REG_W-1:0]    stat_word,
  output mode_t               mode_q,
  output logic [REG_W-1:0]    dbase_q,
  output logic [REG_W-1:0]    sbase_q,
  output logic                launch_hit,
  output logic                launch_encode
);

  localparam logic [ADDR_W-1:0] A_MODE   = ADDR_W'(OFS_MODE);
  localparam logic [ADDR_W-1:0] A_LAUNCH = ADDR_W'(OFS_LAUNCH);
  localparam logic [ADDR_W-1:0] A_DBASE  = ADDR_W'(OFS_DBASE);
  localparam logic [ADDR_W-1:0] A_SBASE  = ADDR_W'(OFS_SBASE);
  localparam logic [ADDR_W-1:0] A_STAT   = ADDR_W'(OFS_STAT);

  logic wr_en;
  assign wr_en         = bus_sel && bus_we;
  assign launch_hit    = wr_en && (bus_addr == A_LAUNCH);
  assign launch_encode = bus_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      dbase_q <= '0;
      sbase_q <= '0;
    end else if (wr_en) begin
      if (bus_addr == A_MODE) begin
        mode_q.wide  <= bus_wdata[MODE_WIDE_BIT];
        mode_q.exact <= bus_wdata[MODE_EXACT_BIT];
        mode_q.burst <= bus_wdata[MODE_BURST_LO +: 2];
      end
      if (bus_addr == A_DBASE) dbase_q <= bus_wdata;
      if (bus_addr == A_SBASE) sbase_q <= bus_wdata;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_we) begin
      unique case (bus_addr)
        A_MODE:  bus_rdata = mode_word(mode_q);
        A_DBASE: bus_rdata = dbase_q;
        A_SBASE: bus_rdata = sbase_q;
        A_STAT:  bus_rdata = stat_word;
        default: bus_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/nand_ecc_front_seq.sv
module nand_ecc_front_seq
  import nand_ecc_front_pkg::*;
#(
  parameter int DATA_BYTES = 512,
  parameter int SIDE_NARROW = 16,
  parameter int SIDE_WIDE = 28,
  localparam int DLEN_W = $clog2(DATA_BYTES + 1),
  localparam int SLEN_W = $clog2(SIDE_WIDE + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               launch_hit,
  input  logic               launch_encode,
  input  mode_t              mode_q,
  input  logic [REG_W-1:0]   dbase_q,
  input  logic [REG_W-1:0]   sbase_q,
  input  logic               rsp_valid_i,
  input  logic               rsp_fail_i,
  input  logic               rsp_erased_i,
  input  logic [CNT_W-1:0]   rsp_count_i,
  output logic               busy_o,
  output logic               req_valid_o,
  output logic               req_encode_o,
  output logic               req_wide_o,
  output logic               req_exact_o,
  output logic [1:0]         req_burst_o,
  output logic [REG_W-1:0]   req_data_addr_o,
  output logic [REG_W-1:0]   req_side_addr_o,
  output logic [DLEN_W-1:0]  req_data_len_o,
  output logic [SLEN_W-1:0]  req_side_len_o,
  output logic               done_pulse_o,
  output logic               st_fail_q,
  output logic               st_erased_q,
  output logic [CNT_W-1:0]   st_count_q
);

  // named internal events
  logic bases_ok;
  logic accept_ev;
  logic finish_ev;

  assign bases_ok  = word_aligned(dbase_q) && word_aligned(sbase_q);
  assign accept_ev = launch_hit && !busy_o && bases_ok;
  assign finish_ev = rsp_valid_i && busy_o;

  assign req_data_len_o = DLEN_W'(DATA_BYTES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o          <= 1'b0;
      req_valid_o     <= 1'b0;
      req_encode_o    <= 1'b0;
      req_wide_o      <= 1'b0;
      req_exact_o     <= 1'b0;
      req_burst_o     <= '0;
      req_data_addr_o <= '0;
      req_side_addr_o <= '0;
      req_side_len_o  <= '0;
      done_pulse_o    <= 1'b0;
      st_fail_q       <= 1'b0;
      st_erased_q     <= 1'b0;
      st_count_q      <= '0;
    end else begin
      req_valid_o  <= accept_ev;
      done_pulse_o <= finish_ev;
      if (accept_ev) begin
        busy_o          <= 1'b1;
        req_encode_o    <= launch_encode;
        req_wide_o      <= mode_q.wide;
        req_exact_o     <= mode_q.exact;
        req_burst_o     <= mode_q.burst;
        req_data_addr_o <= dbase_q;
        req_side_addr_o <= sbase_q;
        req_side_len_o  <= mode_q.wide ? SLEN_W'(SIDE_WIDE) : SLEN_W'(SIDE_NARROW);
        st_fail_q       <= 1'b0;
        st_erased_q     <= 1'b0;
        st_count_q      <= '0;
      end else if (finish_ev) begin
        busy_o      <= 1'b0;
        st_fail_q   <= rsp_fail_i;
        st_erased_q <= rsp_erased_i;
        st_count_q  <= rsp_count_i;
      end
    end
  end

  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o |=> !req_valid_o); // R3
  AST_REQ_WITH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o |-> busy_o); // R3
  AST_BUSY_LAUNCH_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (launch_hit && busy_o) |=> !req_valid_o); // R6
  AST_MISALIGN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (launch_hit && !bases_ok) |=> !req_valid_o); // R5
  AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o |-> (req_data_addr_o[1:0] == 2'b00 && req_side_addr_o[1:0] == 2'b00)); // R5
  AST_DONE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse_o |-> (!busy_o && $past(busy_o))); // R7
  AST_IDLE_RSP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_i && !busy_o) |=> !done_pulse_o); // R8
  AST_FIELDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept_ev && !finish_ev) |=> ($stable(st_count_q) && $stable(st_fail_q) && $stable(st_erased_q))); // R9

endmodule

// File: rtl/nand_ecc_front.sv
module nand_ecc_front
  import nand_ecc_front_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_BYTES = 512,
  parameter int SPARE_BYTES = 6,
  parameter int PARITY_NARROW = 10,
  parameter int PARITY_WIDE = 20,
  localparam int SIDE_NARROW = round_up4(SPARE_BYTES + PARITY_NARROW),
  localparam int SIDE_WIDE = round_up4(SPARE_BYTES + PARITY_WIDE),
  localparam int DLEN_W = $clog2(DATA_BYTES + 1),
  localparam int SLEN_W = $clog2(SIDE_WIDE + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               req_valid_o,
  output logic               req_encode_o,
  output logic               req_wide_o,
  output logic               req_exact_o,
  output logic [1:0]         req_burst_o,
  output logic [31:0]        req_data_addr_o,
  output logic [31:0]        req_side_addr_o,
  output logic [DLEN_W-1:0]  req_data_len_o,
  output logic [SLEN_W-1:0]  req_side_len_o,
  input  logic               rsp_valid_i,
  input  logic               rsp_fail_i,
  input  logic               rsp_erased_i,
  input  logic [7:0]         rsp_count_i,
  output logic               busy_o,
  output logic               done_pulse_o
);

  mode_t            mode_q;
  logic [REG_W-1:0] dbase_q;
  logic [REG_W-1:0] sbase_q;
  logic             launch_hit;
  logic             launch_encode;
  logic             st_fail_q;
  logic             st_erased_q;
  logic [CNT_W-1:0] st_count_q;
  logic [REG_W-1:0] stat_word;

  assign stat_word = status_word(busy_o, st_erased_q, st_fail_q, st_count_q);

  nand_ecc_front_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_sel       (bus_sel),
    .bus_we        (bus_we),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .stat_word     (stat_word),
    .mode_q        (mode_q),
    .dbase_q       (dbase_q),
    .sbase_q       (sbase_q),
    .launch_hit    (launch_hit),
    .launch_encode (launch_encode)
  );

  nand_ecc_front_seq #(
    .DATA_BYTES  (DATA_BYTES),
    .SIDE_NARROW (SIDE_NARROW),
    .SIDE_WIDE   (SIDE_WIDE)
  ) u_seq (
    .clk             (clk),
    .rst_n           (rst_n),
    .launch_hit      (launch_hit),
    .launch_encode   (launch_encode),
    .mode_q          (mode_q),
    .dbase_q         (dbase_q),
    .sbase_q         (sbase_q),
    .rsp_valid_i     (rsp_valid_i),
    .rsp_fail_i      (rsp_fail_i),
    .rsp_erased_i    (rsp_erased_i),
    .rsp_count_i     (rsp_count_i),
    .busy_o          (busy_o),
    .req_valid_o     (req_valid_o),
    .req_encode_o    (req_encode_o),
    .req_wide_o      (req_wide_o),
    .req_exact_o     (req_exact_o),
    .req_burst_o     (req_burst_o),
    .req_data_addr_o (req_data_addr_o),
    .req_side_addr_o (req_side_addr_o),
    .req_data_len_o  (req_data_len_o),
    .req_side_len_o  (req_side_len_o),
    .done_pulse_o    (done_pulse_o),
    .st_fail_q       (st_fail_q),
    .st_erased_q     (st_erased_q),
    .st_count_q      (st_count_q)
  );

endmodule

// File: tb/sim_nand_ecc_front.sv
module sim_nand_ecc_front;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        req_valid_o, req_encode_o, req_wide_o, req_exact_o;
  logic [1:0]  req_burst_o;
  logic [31:0] req_data_addr_o, req_side_addr_o;
  logic [9:0]  req_data_len_o;
  logic [4:0]  req_side_len_o;
  logic        rsp_valid_i = 1'b0;
  logic        rsp_fail_i = 1'b0;
  logic        rsp_erased_i = 1'b0;
  logic [7:0]  rsp_count_i = '0;
  logic        busy_o, done_pulse_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  nand_ecc_front u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .req_valid_o(req_valid_o), .req_encode_o(req_encode_o),
    .req_wide_o(req_wide_o), .req_exact_o(req_exact_o),
    .req_burst_o(req_burst_o), .req_data_addr_o(req_data_addr_o),
    .req_side_addr_o(req_side_addr_o), .req_data_len_o(req_data_len_o),
    .req_side_len_o(req_side_len_o), .rsp_valid_i(rsp_valid_i),
    .rsp_fail_i(rsp_fail_i), .rsp_erased_i(rsp_erased_i),
    .rsp_count_i(rsp_count_i), .busy_o(busy_o), .done_pulse_o(done_pulse_o)
  );

  // expected status word built from the R7 field positions
  function automatic logic [31:0] exp_status(input logic busy, input logic erased,
                                             input logic fail, input logic [7:0] cnt);
    return {12'h000, cnt, 3'b000, fail, 3'b000, erased, 3'b000, busy};
  endfunction

  task automatic check(input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s : got %h expected %h", what, got, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #2 d = bus_rdata;
    #2 bus_sel = 1'b0;
  endtask

  task automatic respond(input logic fail, input logic erased, input logic [7:0] cnt);
    @(negedge clk);
    rsp_valid_i = 1'b1; rsp_fail_i = fail; rsp_erased_i = erased; rsp_count_i = cnt;
    @(negedge clk);
    rsp_valid_i = 1'b0; rsp_fail_i = 1'b0; rsp_erased_i = 1'b0; rsp_count_i = '0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 busy", {31'd0, busy_o}, 32'd0);
    check("R1 req_valid", {31'd0, req_valid_o}, 32'd0);
    check("R1 done", {31'd0, done_pulse_o}, 32'd0);
    bus_read(8'h14, v); check("R1 status", v, 32'd0);
    bus_read(8'h00, v); check("R1 mode", v, 32'd0);
    bus_read(8'h0C, v); check("R1 data base", v, 32'd0);
  endtask

  task automatic t_mode_regs();
    logic [31:0] v;
    bus_write(8'h00, 32'hFFFF_FFFF);
    bus_read(8'h00, v); check("R2 mode mask", v, 32'h1000_1003);
    bus_write(8'h0C, 32'h8000_1200);
    bus_read(8'h0C, v); check("R2 data base", v, 32'h8000_1200);
    bus_write(8'h10, 32'h8000_1400);
    bus_read(8'h10, v); check("R2 spare base", v, 32'h8000_1400);
  endtask

  task automatic t_encode_narrow();
    logic [31:0] v;
    bus_write(8'h00, 32'h0000_1003);
    bus_write(8'h08, 32'h1);
    check("R3 busy rises", {31'd0, busy_o}, 32'd1);
    check("R3 req_valid", {31'd0, req_valid_o}, 32'd1);
    check("R3 encode", {31'd0, req_encode_o}, 32'd1);
    check("R3 data addr", req_data_addr_o, 32'h8000_1200);
    check("R3 spare addr", req_side_addr_o, 32'h8000_1400);
    check("R2 exact/burst", {29'd0, req_exact_o, req_burst_o}, 32'd7);
    check("R4 narrow side len", {27'd0, req_side_len_o}, 32'd16);
    check("R4 data len", {22'd0, req_data_len_o}, 32'd512);
    @(negedge clk);
    check("R3 req one cycle", {31'd0, req_valid_o}, 32'd0);
    bus_read(8'h14, v); check("R7 busy bit", v, exp_status(1'b1, 1'b0, 1'b0, 8'h00));
    respond(1'b0, 1'b0, 8'h00);
    check("R7 busy falls", {31'd0, busy_o}, 32'd0);
    check("R7 done pulse", {31'd0, done_pulse_o}, 32'd1);
    @(negedge clk);
    check("R7 done single", {31'd0, done_pulse_o}, 32'd0);
  endtask

  task automatic t_decode_wide();
    logic [31:0] v;
    bus_write(8'h00, 32'h1000_1003);
    bus_write(8'h08, 32'h0);
    check("R3 decode req", {30'd0, req_valid_o, req_encode_o}, 32'd2);
    check("R4 wide side len", {27'd0, req_side_len_o}, 32'd28);
    check("R4 wide flag", {31'd0, req_wide_o}, 32'd1);
    bus_write(8'h08, 32'h1);
    check("R6 no second req", {31'd0, req_valid_o}, 32'd0);
    check("R6 still busy", {31'd0, busy_o}, 32'd1);
    check("R6 encode kept", {31'd0, req_encode_o}, 32'd0);
    respond(1'b1, 1'b0, 8'h05);
    check("R7 done after fail", {31'd0, done_pulse_o}, 32'd1);
    bus_read(8'h14, v); check("R7 fail+count", v, exp_status(1'b0, 1'b0, 1'b1, 8'h05));
    repeat (5) @(negedge clk);
    bus_read(8'h14, v); check("R9 held", v, 32'h0000_5100);
    respond(1'b0, 1'b1, 8'h09);
    check("R8 no done idle", {31'd0, done_pulse_o}, 32'd0);
    bus_read(8'h14, v); check("R8 idle rsp ignored", v, 32'h0000_5100);
  endtask

  task automatic t_misalign();
    logic [31:0] v;
    bus_write(8'h10, 32'h8000_1402);
    bus_write(8'h08, 32'h1);
    check("R5 spare misalign no req", {30'd0, req_valid_o, busy_o}, 32'd0);
    bus_read(8'h14, v); check("R5 status kept", v, 32'h0000_5100);
    bus_write(8'h10, 32'h8000_1400);
    bus_write(8'h0C, 32'h8000_1201);
    bus_write(8'h08, 32'h0);
    check("R5 data misalign no req", {30'd0, req_valid_o, busy_o}, 32'd0);
    bus_write(8'h0C, 32'h8000_1200);
  endtask

  task automatic t_clear_on_launch();
    logic [31:0] v;
    bus_write(8'h08, 32'h0);
    bus_read(8'h14, v); check("R9 cleared on launch", v, exp_status(1'b1, 1'b0, 1'b0, 8'h00));
    respond(1'b0, 1'b1, 8'h03);
    bus_read(8'h14, v); check("R7 erased+count", v, exp_status(1'b0, 1'b1, 1'b0, 8'h03));
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    bus_read(8'h04, v); check("R10 read 0x04", v, 32'd0);
    bus_read(8'h08, v); check("R10 read 0x08", v, 32'd0);
    bus_read(8'h18, v); check("R10 read 0x18", v, 32'd0);
    bus_write(8'h14, 32'hFFFF_FFFF);
    check("R10 status write no launch", {30'd0, req_valid_o, busy_o}, 32'd0);
    bus_read(8'h14, v); check("R10 status write ignored", v, 32'h0000_3010);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mode_regs();
    t_encode_narrow();
    t_decode_wide();
    t_misalign();
    t_clear_on_launch();
    t_unmapped();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule